// File: doc/BRIEF.md
# Stop-mode wake-up sequencer

This block decides when a small processor may run again after a low-power stop. A one-cycle stop strobe from the core gates off every clock enable it owns: oscillator, optional PLL, peripherals, CPU core and bus interface. Once stopped, the block waits for a qualifying wake interrupt. The interrupt restarts the oscillator, and the PLL too if the PLL is configured on. The block then holds the CPU and the bus interface off until the oscillator has had time to settle.

The settling time is measured in one of two ways. In watchdog mode, the watchdog counter is reused as the stabilisation timer. It is loaded with all ones and counts down on a prescaled oscillator tap. The CPU and bus clocks come back when the counter's top bit falls, and this fall raises no watchdog interrupt. In bypass mode, a fixed number of clock cycles is counted instead. The wake interrupt is kept pending until the CPU clock is back, and is then handed to the core as accepted.

While running, the counter keeps counting on the selected tap. Each fall of its top bit in that state raises a one-cycle watchdog interrupt pulse.

Top module: `stop_wake_seq`

## Requirements
- R1: While rst_ni is low, all of these hold: osc_en_o, periph_clk_en_o, cpu_clk_en_o and biu_clk_en_o are 1; pll_en_o equals pll_cfg_i; wdt_cnt_o is all ones; wake_ack_o and wdt_irq_o are 0.
- R2: A stop strobe seen at a clock edge while running sets osc_en_o, pll_en_o, periph_clk_en_o, cpu_clk_en_o and biu_clk_en_o to 0 from that edge on. cpu_clk_en_o is never 1 while osc_en_o is 0.
- R3: A wake interrupt seen at an edge while stopped sets osc_en_o and periph_clk_en_o to 1 from that edge, with pll_en_o equal to pll_cfg_i. It also loads wdt_cnt_o with all ones. cpu_clk_en_o and biu_clk_en_o stay 0.
- R4: The prescaler is cleared when stop is entered. In watchdog mode the counter then decrements once every 16 << clk_sel_i clock cycles (select 0, 1, 2, 3 give 16, 32, 64, 128). As a result, cpu_clk_en_o rises exactly (16 << sel) * 2^(CNT_W-1) edges after the wake edge.
- R5: In watchdog mode, cpu_clk_en_o rises at the edge where wdt_cnt_o goes from 1 followed by zeros to 0 followed by ones.
- R6: The top-bit fall during wake-up raises no wdt_irq_o. While running, a top-bit fall gives a one-cycle wdt_irq_o pulse, starting at the edge where the counter reaches 0 followed by ones.
- R7: clk_sel_i and wdt_wait_i are sampled at the wake edge. Changes to them after that edge do not alter the wake-up latency.
- R8: With wdt_wait_i = 0 at the wake edge (bypass), cpu_clk_en_o rises exactly EXT_DLY + 1 edges after the wake edge.
- R9: wake_ack_o is a one-cycle pulse. It occurs in the first cycle after a stop in which cpu_clk_en_o and biu_clk_en_o are 1, and is 0 at all other times.
- R10: A wake interrupt while running is ignored: the enables stay at 1, wake_ack_o stays 0 and the counter is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stp_i | input | 1 | Stop strobe from the core |
| wake_irq_i | input | 1 | Qualifying wake interrupt request |
| wdt_wait_i | input | 1 | 1: counter-based wait, 0: fixed-delay bypass |
| pll_cfg_i | input | 1 | PLL enabled in configuration |
| clk_sel_i | input | SEL_W | Counter tap: divide by 16 << value |
| osc_en_o | output | 1 | Oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| biu_clk_en_o | output | 1 | Bus-interface clock enable |
| wake_ack_o | output | 1 | Wake interrupt passed on as accepted |
| wdt_irq_o | output | 1 | Watchdog interrupt pulse |
| wdt_cnt_o | output | CNT_W | Watchdog / stabilisation counter value |

## Verification
The bench builds the block with CNT_W = 6 and EXT_DLY = 20. With these values the counter needs 32 decrements, so even the divide-by-128 wake-up completes in 4096 cycles. That keeps every tap setting, the suppressed wake-time fall and a full running-state watchdog fall within one short run. The small bypass delay lets the exact EXT_DLY + 1 latency be checked in both select settings.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [2:0] {
    S_RUN    = 3'd0,
    S_STOP   = 3'd1,
    S_OSC    = 3'd2,
    S_COUNT  = 3'd3,
    S_RESUME = 3'd4
  } wake_state_e;
endpackage

// File: rtl/wake_prescaler.sv
module wake_prescaler #(
  parameter int SEL_W    = 2,
  parameter int BASE_LOG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NTAP  = 2 ** SEL_W;
  localparam int PRE_W = BASE_LOG + NTAP - 1;

  logic [PRE_W-1:0] pre_q;
  logic [NTAP-1:0]  tap_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= pre_q + 1'b1;
  end

  // tap i fires once every 2^(BASE_LOG+i) running cycles
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    assign tap_hit[i] = &pre_q[BASE_LOG+i-1:0];
  end

  assign tick_o = run_i & tap_hit[sel_i];

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R4
endmodule

// File: rtl/wake_stab_timer.sv
module wake_stab_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             suppress_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fall_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '1;
    else if (load_i)          cnt_q <= '1;
    else if (en_i && tick_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign fall_o = en_i & tick_i & (cnt_q == HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fall_o & ~suppress_i;
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_LOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '1)); // R3
  AST_FALL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o && !load_i) |=> (cnt_q == {1'b0, {(CNT_W-1){1'b1}}})); // R5
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import stop_wake_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int EXT_DLY = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stp_i,
  input  logic             wake_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             fall_i,
  output wake_state_e      state_o,
  output logic             mode_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             load_o,
  output logic             stop_entry_o
);
  localparam int DLY_W = $clog2(EXT_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(EXT_DLY - 1);

  wake_state_e      state_q, state_d;
  logic [DLY_W-1:0] dly_q;
  logic             mode_q;
  logic [SEL_W-1:0] sel_q;

  assign load_o       = (state_q == S_STOP) & wake_i;
  assign stop_entry_o = (state_q == S_RUN) & stp_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RUN:    if (stp_i)  state_d = S_STOP;
      S_STOP:   if (wake_i) state_d = S_OSC;
      S_OSC:    state_d = S_COUNT;
      S_COUNT: begin
        if (mode_q ? fall_i : (dly_q == DLY_LAST)) state_d = S_RESUME;
      end
      S_RESUME: state_d = S_RUN;
      default:  state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RUN;
      dly_q   <= '0;
      mode_q  <= 1'b1;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        mode_q <= mode_i;
        sel_q  <= sel_i;
      end
      if (state_q == S_COUNT) dly_q <= dly_q + 1'b1;
      else                    dly_q <= '0;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign sel_o   = sel_q;

  AST_RUN_WAKE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RUN && !stp_i) |=> (state_q == S_RUN)); // R10
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STOP && !wake_i) |=> (state_q == S_STOP)); // R2
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import stop_wake_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int SEL_W   = 2,
  parameter int EXT_DLY = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stp_i,
  input  logic             wake_irq_i,
  input  logic             wdt_wait_i,
  input  logic             pll_cfg_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             periph_clk_en_o,
  output logic             cpu_clk_en_o,
  output logic             biu_clk_en_o,
  output logic             wake_ack_o,
  output logic             wdt_irq_o,
  output logic [CNT_W-1:0] wdt_cnt_o
);
  localparam int BASE_LOG = 4;

  wake_state_e      state;
  logic             mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             load, stop_entry, tick, fall, cnt_en, osc_on, cpu_on;

  wake_fsm #(.SEL_W(SEL_W), .EXT_DLY(EXT_DLY)) u_fsm (
    .clk_i, .rst_ni, .stp_i,
    .wake_i       (wake_irq_i),
    .mode_i       (wdt_wait_i),
    .sel_i        (clk_sel_i),
    .fall_i       (fall),
    .state_o      (state),
    .mode_o       (mode_q),
    .sel_o        (sel_q),
    .load_o       (load),
    .stop_entry_o (stop_entry)
  );

  assign osc_on = (state != S_STOP);
  assign cpu_on = (state == S_RUN) || (state == S_RESUME);
  assign cnt_en = cpu_on || ((state == S_COUNT) && mode_q);

  wake_prescaler #(.SEL_W(SEL_W), .BASE_LOG(BASE_LOG)) u_pre (
    .clk_i, .rst_ni,
    .clr_i  (stop_entry),
    .run_i  (osc_on),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  wake_stab_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i     (load),
    .en_i       (cnt_en),
    .tick_i     (tick),
    .suppress_i (state != S_RUN),
    .cnt_o      (wdt_cnt_o),
    .fall_o     (fall),
    .irq_o      (wdt_irq_o)
  );

  assign osc_en_o        = osc_on;
  assign periph_clk_en_o = osc_on;
  assign pll_en_o        = osc_on & pll_cfg_i;
  assign cpu_clk_en_o    = cpu_on;
  assign biu_clk_en_o    = cpu_on;
  assign wake_ack_o      = (state == S_RESUME);

  AST_CPU_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> osc_en_o); // R2
  AST_ACK_FIRST_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_ack_o |-> (cpu_clk_en_o && !$past(cpu_clk_en_o))); // R9
  AST_RELEASE_AT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cpu_clk_en_o) && mode_q) |-> (wdt_cnt_o == {1'b0, {(CNT_W-1){1'b1}}})); // R5
  AST_IRQ_ONLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_irq_o |-> $past(state == S_RUN)); // R6
  AST_OSC_BEFORE_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !cpu_clk_en_o); // R3
endmodule

// File: tb/sim_stop_wake_seq.sv
module sim_stop_wake_seq;
  localparam int CNT_W   = 6;
  localparam int SEL_W   = 2;
  localparam int EXT_DLY = 20;

  logic clk_i = 1'b0;
  logic rst_ni, stp_i, wake_irq_i, wdt_wait_i, pll_cfg_i;
  logic [SEL_W-1:0] clk_sel_i;
  logic osc_en_o, pll_en_o, periph_clk_en_o, cpu_clk_en_o, biu_clk_en_o;
  logic wake_ack_o, wdt_irq_o;
  logic [CNT_W-1:0] wdt_cnt_o;

  always #5 clk_i = ~clk_i;

  stop_wake_seq #(.CNT_W(CNT_W), .SEL_W(SEL_W), .EXT_DLY(EXT_DLY)) u0 (.*);

  typedef struct packed {
    logic       mode;
    logic [1:0] sel;
    logic       pll;
    logic [1:0] sel_after;
    logic [31:0] exp_lat;
  } vec_t;

  // wdt latency = (16 << sel) * 32; bypass latency = EXT_DLY + 1
  localparam vec_t VEC [6] = '{
    '{1'b1, 2'd0, 1'b0, 2'd3, 32'd512},
    '{1'b1, 2'd1, 1'b1, 2'd0, 32'd1024},
    '{1'b1, 2'd2, 1'b0, 2'd1, 32'd2048},
    '{1'b1, 2'd3, 1'b1, 2'd2, 32'd4096},
    '{1'b0, 2'd2, 1'b1, 2'd0, 32'd21},
    '{1'b0, 2'd0, 1'b0, 2'd3, 32'd21}
  };

  int n_chk = 0, n_fail = 0, irq_seen = 0;
  logic mon_en = 1'b0;

  always @(negedge clk_i) if (mon_en && wdt_irq_o) irq_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lat;
    rst_ni = 1'b0; stp_i = 1'b0; wake_irq_i = 1'b0;
    wdt_wait_i = 1'b1; pll_cfg_i = 1'b1; clk_sel_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(osc_en_o && periph_clk_en_o && cpu_clk_en_o && biu_clk_en_o, "R1 enables",
        {osc_en_o, periph_clk_en_o, cpu_clk_en_o, biu_clk_en_o}, 15);
    chk(pll_en_o == 1'b1, "R1 pll", pll_en_o, 1);
    chk(wdt_cnt_o == 6'd63, "R1 cnt", wdt_cnt_o, 63);
    chk(!wake_ack_o && !wdt_irq_o, "R1 ack/irq", {wake_ack_o, wdt_irq_o}, 0);
    rst_ni = 1'b1;

    // R6 running-state fall gives one pulse at edge 512 after reset
    repeat (511) @(posedge clk_i);
    @(negedge clk_i);
    chk(!wdt_irq_o && wdt_cnt_o == 6'd32, "R6 before fall", {wdt_irq_o, wdt_cnt_o}, 32);
    @(negedge clk_i);
    chk(wdt_irq_o && wdt_cnt_o == 6'd31, "R6 run pulse", {wdt_irq_o, wdt_cnt_o}, 95);
    @(negedge clk_i);
    chk(!wdt_irq_o, "R6 pulse width", wdt_irq_o, 0);

    // R10 wake while running
    wake_irq_i = 1'b1;
    @(negedge clk_i);
    wake_irq_i = 1'b0;
    @(negedge clk_i);
    chk(wdt_cnt_o == 6'd31, "R10 no reload", wdt_cnt_o, 31);
    chk(cpu_clk_en_o && osc_en_o && !wake_ack_o, "R10 enables",
        {cpu_clk_en_o, osc_en_o, wake_ack_o}, 6);

    for (int v = 0; v < 6; v++) begin
      repeat (7) @(negedge clk_i);
      stp_i = 1'b1;
      @(negedge clk_i);
      stp_i = 1'b0;
      // R2 everything gated
      chk(!osc_en_o && !pll_en_o && !periph_clk_en_o && !cpu_clk_en_o && !biu_clk_en_o,
          "R2 stop", {osc_en_o, pll_en_o, periph_clk_en_o, cpu_clk_en_o, biu_clk_en_o}, 0);
      repeat (3) @(negedge clk_i);
      clk_sel_i = VEC[v].sel; wdt_wait_i = VEC[v].mode; pll_cfg_i = VEC[v].pll;
      wake_irq_i = 1'b1; mon_en = 1'b1; irq_seen = 0;
      @(negedge clk_i);
      wake_irq_i = 1'b0;
      clk_sel_i = VEC[v].sel_after;      // R7 late change
      wdt_wait_i = ~VEC[v].mode;         // R7 late change
      chk(osc_en_o && periph_clk_en_o && !cpu_clk_en_o && !biu_clk_en_o, "R3 osc first",
          {osc_en_o, periph_clk_en_o, cpu_clk_en_o, biu_clk_en_o}, 12);
      chk(pll_en_o == VEC[v].pll, "R3 pll", pll_en_o, VEC[v].pll);
      chk(wdt_cnt_o == 6'd63, "R3 load", wdt_cnt_o, 63);
      lat = 0;
      while (lat < 10000) begin
        @(posedge clk_i);
        lat++;
        @(negedge clk_i);
        if (cpu_clk_en_o) break;
      end
      if (VEC[v].mode) begin
        chk(lat == int'(VEC[v].exp_lat), "R4 R7 wdt latency", lat, VEC[v].exp_lat);
        chk(wdt_cnt_o == 6'd31, "R5 release value", wdt_cnt_o, 31);
      end else begin
        chk(lat == int'(VEC[v].exp_lat), "R8 R7 bypass latency", lat, VEC[v].exp_lat);
      end
      chk(wake_ack_o && biu_clk_en_o, "R9 ack with cpu", {wake_ack_o, biu_clk_en_o}, 3);
      @(negedge clk_i);
      mon_en = 1'b0;
      chk(!wake_ack_o, "R9 ack one cycle", wake_ack_o, 0);
      chk(irq_seen == 0, "R6 suppressed", irq_seen, 0);
    end
    finish_run();
  end
endmodule